// File: doc/BRIEF.md
# Flash Command Interpreter

This block is the command front end for a small on-chip flash array. A host issues 16-bit requests over a valid/ready request channel. Each request is a write or a read at an even byte address. Writes carry command codes, or the data and confirm cycles of two-cycle sequences. Only the low byte of a command word is decoded. Reads return a response one cycle later. The response comes from the array, the status byte or a block's lock flag, depending on the current read mode. That mode stays in force until another command changes it.

Two-cycle operations are armed by a setup code and act only on the second write. Word program expects a data write to the same address. Block erase, erase of all unlocked blocks, lock set and lock query all expect the confirm code D0h. A wrong second cycle aborts the sequence and sets an error bit.

A successful program, erase or lock set starts a fixed busy window. While it runs, the ready bit reads 0, every read returns the status byte, and all writes are accepted and dropped. The request channel never applies back-pressure, so `cmd_ready` is always high. The response side has no ready input and must be consumed in the cycle it is valid.

Top module: `fcsm_top`

## Requirements
- R1: After reset the read mode is array, every word reads FFFFh, all blocks are unlocked and the status byte is 80h.
- R2: Code FFh selects array mode. Each later read returns the word at the addressed location, until another command is written. Bits 15..8 of any command write are ignored.
- R3: Code 70h selects status mode. Reads from any even address then return {8'h00, status}. The status byte is bit 7 = ready, bit 5 = erase/lock error, bit 4 = program error, and all other bits 0.
- R4: Code 50h is a single write that clears status bits 5 and 4 and leaves the read mode unchanged.
- R5: Writing 40h at a word address, then data at that same address, stores the data there. If the second write goes to a different address, nothing is stored and status bit 4 is set.
- R6: Writing 20h, then D0h at any address inside a block, sets every word of that block to FFFFh. If the second code is not D0h, nothing is changed and status bit 5 is set.
- R7: Writing A7h, then D0h, erases every unlocked block except block PROT_BLK. That block is never erased by this sequence.
- R8: Writing 77h, then D0h at a block address, locks the block until reset. A program to a locked block changes nothing and sets bit 4. An erase of a locked block changes nothing and sets bit 5.
- R9: Writing 71h, then D0h at a block address, selects lock mode. Reads then return 0040h if that block is locked and 0000h if it is not.
- R10: After a successful program, erase or lock set, exactly BUSY_CYCLES following reads return status with bit 7 = 0. Writes during that window have no effect.
- R11: `cmd_ready` is always 1. `rsp_valid` is 1 in the cycle after each accepted read and 0 otherwise.
- R12: Completing or aborting any two-cycle sequence selects status mode, except a confirmed lock query, which selects lock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request accepted (always 1) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address, bit 0 ignored |
| cmd_wdata | input | 16 | Command code or program data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Read response word |

## Verification
A read sampled at a clock edge produces its response at that same edge, so the bench samples `rsp_data` shortly after the edge on which the read was accepted. A program, erase or lock set takes effect at the edge that accepts the second write. The busy window then covers exactly the next BUSY_CYCLES edges. The bench checks this by issuing back-to-back reads and counting those that show ready low. Array and lock effects are checked only through later reads, after the mode command that exposes them. Status bits are compared after each sequence against a bench model of array, locks and error flags.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLEAR_STAT = 8'h50;
  localparam logic [7:0] OP_PROGRAM    = 8'h40;
  localparam logic [7:0] OP_ERASE_BLK  = 8'h20;
  localparam logic [7:0] OP_ERASE_ALL  = 8'hA7;
  localparam logic [7:0] OP_LOCK_SET   = 8'h77;
  localparam logic [7:0] OP_LOCK_QUERY = 8'h71;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_LOCK} rmode_e;
  typedef enum logic [2:0] {ARM_NONE, ARM_PROG, ARM_ERASE, ARM_ALL, ARM_LOCK, ARM_QUERY} arm_e;
endpackage

// File: rtl/fcsm_timer.sv
module fcsm_timer #(
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fcsm_array.sv
module fcsm_array #(
  parameter int NUM_BLOCKS = 4,
  parameter int WPB        = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               prog_en,
  input  logic [$clog2(NUM_BLOCKS*WPB)-1:0]  prog_idx,
  input  logic [15:0]                        prog_data,
  input  logic [NUM_BLOCKS-1:0]              erase_mask,
  input  logic                               lock_en,
  input  logic [$clog2(NUM_BLOCKS)-1:0]      lock_blk,
  input  logic [$clog2(NUM_BLOCKS*WPB)-1:0]  rd_idx,
  output logic [15:0]                        rd_word,
  output logic [NUM_BLOCKS-1:0]              locks
);
  localparam int NW = NUM_BLOCKS * WPB;
  logic [15:0] mem [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                   mem[w] <= 16'hFFFF;
      else if (erase_mask[w / WPB])                 mem[w] <= 16'hFFFF;
      else if (prog_en && (int'(prog_idx) == w))    mem[w] <= prog_data;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n)                               locks[b] <= 1'b0;
      else if (lock_en && (int'(lock_blk) == b)) locks[b] <= 1'b1;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/fcsm_seq.sv
module fcsm_seq
  import fcsm_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int WPB        = 8,
  parameter int PROT_BLK   = 0,
  localparam int IDX_W     = $clog2(NUM_BLOCKS*WPB),
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [IDX_W-1:0]      widx,
  input  logic [15:0]           wdata,
  input  logic                  busy,
  input  logic [NUM_BLOCKS-1:0] locks,
  output logic                  prog_en,
  output logic [NUM_BLOCKS-1:0] erase_mask,
  output logic                  lock_en,
  output logic [BLK_W-1:0]      op_blk,
  output logic                  start,
  output rmode_e                rmode,
  output logic [BLK_W-1:0]      query_blk,
  output logic                  err_erase,
  output logic                  err_prog
);
  arm_e             arm;
  logic [IDX_W-1:0] arm_idx;
  logic [7:0]       code;
  logic             take, first, second, confirm, blk_locked, set_perr, set_eerr, clr;

  assign code       = wdata[7:0];
  assign op_blk     = widx[IDX_W-1 -: BLK_W];
  assign take       = wr_fire && !busy;
  assign first      = take && (arm == ARM_NONE);
  assign second     = take && (arm != ARM_NONE);
  assign confirm    = (code == OP_CONFIRM);
  assign blk_locked = locks[op_blk];
  assign clr        = first && (code == OP_CLEAR_STAT);

  assign prog_en  = second && (arm == ARM_PROG) && (widx == arm_idx) && !blk_locked;
  assign lock_en  = second && (arm == ARM_LOCK) && confirm;
  assign set_perr = second && (arm == ARM_PROG) && !((widx == arm_idx) && !blk_locked);
  assign set_eerr = second && (((arm == ARM_ERASE) && !(confirm && !blk_locked)) ||
                               (((arm == ARM_ALL) || (arm == ARM_LOCK) || (arm == ARM_QUERY)) && !confirm));

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_emask
    assign erase_mask[b] = second && confirm &&
      (((arm == ARM_ERASE) && !blk_locked && (int'(op_blk) == b)) ||
       ((arm == ARM_ALL) && !locks[b] && (b != PROT_BLK)));
  end

  assign start = prog_en || (|erase_mask) || lock_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm       <= ARM_NONE;
      arm_idx   <= '0;
      rmode     <= RM_ARRAY;
      query_blk <= '0;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
    end else begin
      err_prog  <= (err_prog | set_perr) & ~clr;
      err_erase <= (err_erase | set_eerr) & ~clr;
      if (first) begin
        arm_idx <= widx;
        case (code)
          OP_READ_ARRAY: rmode <= RM_ARRAY;
          OP_READ_STAT:  rmode <= RM_STATUS;
          OP_PROGRAM:    arm   <= ARM_PROG;
          OP_ERASE_BLK:  arm   <= ARM_ERASE;
          OP_ERASE_ALL:  arm   <= ARM_ALL;
          OP_LOCK_SET:   arm   <= ARM_LOCK;
          OP_LOCK_QUERY: arm   <= ARM_QUERY;
          default: ;
        endcase
      end else if (second) begin
        arm <= ARM_NONE;
        if ((arm == ARM_QUERY) && confirm) begin
          rmode     <= RM_LOCK;
          query_blk <= op_blk;
        end else begin
          rmode <= RM_STATUS;
        end
      end
    end
  end
endmodule

// File: rtl/fcsm_top.sv
module fcsm_top
  import fcsm_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int WPB         = 8,
  parameter int BUSY_CYCLES = 6,
  parameter int PROT_BLK    = 0,
  localparam int IDX_W      = $clog2(NUM_BLOCKS*WPB),
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int ADDR_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data
);
  logic                  wr_fire, rd_fire, busy, start, prog_en, lock_en, err_erase, err_prog;
  logic [IDX_W-1:0]      widx;
  logic [NUM_BLOCKS-1:0] erase_mask, locks;
  logic [BLK_W-1:0]      op_blk, query_blk;
  logic [15:0]           rd_word;
  logic [7:0]            status;
  rmode_e                rmode;

  assign cmd_ready = 1'b1;
  assign wr_fire   = cmd_valid && cmd_write;
  assign rd_fire   = cmd_valid && !cmd_write;
  assign widx      = cmd_addr[ADDR_W-1:1];
  assign status    = {~busy, 1'b0, err_erase, err_prog, 4'b0000};

  fcsm_seq #(.NUM_BLOCKS(NUM_BLOCKS), .WPB(WPB), .PROT_BLK(PROT_BLK)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .widx(widx), .wdata(cmd_wdata),
    .busy(busy), .locks(locks), .prog_en(prog_en), .erase_mask(erase_mask),
    .lock_en(lock_en), .op_blk(op_blk), .start(start), .rmode(rmode),
    .query_blk(query_blk), .err_erase(err_erase), .err_prog(err_prog));

  fcsm_array #(.NUM_BLOCKS(NUM_BLOCKS), .WPB(WPB)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_idx(widx), .prog_data(cmd_wdata),
    .erase_mask(erase_mask), .lock_en(lock_en), .lock_blk(op_blk), .rd_idx(widx),
    .rd_word(rd_word), .locks(locks));

  fcsm_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        if (busy) rsp_data <= {8'h00, status};
        else begin
          case (rmode)
            RM_ARRAY:  rsp_data <= rd_word;
            RM_STATUS: rsp_data <= {8'h00, status};
            default:   rsp_data <= {9'b0, locks[query_blk], 6'b0};
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fcsm_chk.sv
module fcsm_chk #(
  parameter int NUM_BLOCKS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_write,
  input logic                  cmd_ready,
  input logic                  rsp_valid,
  input logic [15:0]           rsp_data,
  input logic                  busy,
  input logic                  start,
  input logic [NUM_BLOCKS-1:0] locks
);
  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready);
  // R11
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> !rsp_valid);
  // R10
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R10
  busy_read_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !cmd_write) |=> (rsp_data[7] == 1'b0));
  // R10
  busy_write_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_write) |=> $stable(locks));
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((locks & $past(locks)) == $past(locks)));
endmodule

bind fcsm_top fcsm_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .busy(busy), .start(start), .locks(locks));

// File: tb/tb_fcsm_top.sv
`timescale 1ns/1ps
module tb_fcsm_top;
  localparam int NB = 4, WPB = 8, BUSY = 6, PROT = 0, NW = NB * WPB, AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid;
  logic [15:0] rsp_data;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model [NW];
  logic [NB-1:0] mlock = '0;
  logic m_ee = 1'b0, m_ep = 1'b0;

  always #2 clk = ~clk;

  fcsm_top #(.NUM_BLOCKS(NB), .WPB(WPB), .BUSY_CYCLES(BUSY), .PROT_BLK(PROT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  function automatic logic [15:0] exp_stat(input logic rdy);
    return {8'h00, rdy, 1'b0, m_ee, m_ep, 4'b0000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = AW'(idx * 2); cmd_wdata = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [15:0] d, output logic v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = AW'(idx * 2);
    @(posedge clk); #1;
    d = rsp_data; v = rsp_valid;
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [15:0] exp, input string tag);
    logic [15:0] d; logic v;
    rd(idx, d, v);
    check(v === 1'b1, "R11 rsp_valid", {15'b0, v}, 16'h1);
    check(d === exp, tag, d, exp);
  endtask

  task automatic wait_ready(output int busy_reads);
    logic [15:0] d; logic v;
    busy_reads = 0;
    for (int i = 0; i < 50; i++) begin
      rd(0, d, v);
      if (d[7]) break;
      busy_reads++;
    end
  endtask

  task automatic prog(input int idx, input logic [15:0] d);
    int n;
    wr(idx, 16'h0040); wr(idx, d);
    if (mlock[idx / WPB]) m_ep = 1'b1; else model[idx] = d;
    wait_ready(n);
  endtask

  task automatic arr_chk(input int idx, input string tag);
    wr(0, 16'h00FF);
    rd_chk(idx, model[idx], tag);
  endtask

  initial begin
    int n;
    logic [15:0] d; logic v;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd_chk(5, 16'hFFFF, "R1 erased after reset");
    check(cmd_ready === 1'b1, "R11 cmd_ready", {15'b0, cmd_ready}, 16'h1);
    wr(0, 16'h0070);
    check(rsp_valid === 1'b0, "R11 no rsp after write", {15'b0, rsp_valid}, 16'h0);
    rd_chk(0, 16'h0080, "R1 status after reset");
    rd_chk(27, 16'h0080, "R3 status at other address");

    // R10 busy length after program
    wr(3, 16'h0040); wr(3, 16'hA5A5); model[3] = 16'hA5A5;
    wait_ready(n);
    check(n == BUSY, "R10 busy read count", 16'(n), 16'(BUSY));
    rd_chk(3, 16'h0080, "R12 status mode after program");
    wr(0, 16'h12FF);
    rd_chk(3, 16'hA5A5, "R2 array read high byte ignored");
    rd_chk(3, 16'hA5A5, "R2 array mode persists");
    rd_chk(4, 16'hFFFF, "R5 neighbour untouched");

    // R10 write ignored while busy
    wr(6, 16'h0040); wr(6, 16'h1111); model[6] = 16'h1111;
    wr(0, 16'h00FF);
    wait_ready(n);
    rd_chk(6, 16'h0080, "R10 write during busy ignored");

    // R5 address mismatch
    wr(7, 16'h0040); wr(8, 16'h2222); m_ep = 1'b1;
    rd_chk(0, exp_stat(1'b1), "R5 mismatch sets bit4");
    arr_chk(8, "R5 mismatch stores nothing");
    wr(0, 16'h0070);
    wr(0, 16'h0050); m_ep = 1'b0;
    rd_chk(0, 16'h0080, "R4 clear keeps status mode");

    // R6 bad confirm
    wr(12, 16'h0020); wr(12, 16'h00FF); m_ee = 1'b1;
    rd_chk(0, exp_stat(1'b1), "R6 abort sets bit5");
    wr(0, 16'h0050); m_ee = 1'b0;

    // R6 block erase
    prog(9, 16'h1234); prog(17, 16'h5678);
    wr(15, 16'h0020); wr(15, 16'h00D0);
    for (int i = 8; i < 16; i++) model[i] = 16'hFFFF;
    wait_ready(n);
    arr_chk(9, "R6 block erased");
    arr_chk(17, "R6 other block kept");

    // R8 lock and R9 query
    wr(20, 16'h0077); wr(20, 16'h00D0); mlock[2] = 1'b1;
    wait_ready(n);
    wr(16, 16'h0071); wr(16, 16'h00D0);
    rd_chk(0, 16'h0040, "R9 locked block query");
    rd_chk(9, 16'h0040, "R9 lock mode persists");
    wr(24, 16'h0071); wr(24, 16'h00D0);
    rd_chk(0, 16'h0000, "R9 unlocked block query");
    prog(17, 16'h9999);
    rd_chk(0, exp_stat(1'b1), "R8 program locked sets bit4");
    arr_chk(17, "R8 locked word unchanged");
    wr(18, 16'h0020); wr(18, 16'h00D0); m_ee = 1'b1;
    rd_chk(0, exp_stat(1'b1), "R8 erase locked sets bit5");
    arr_chk(17, "R8 locked block not erased");
    wr(0, 16'h0050); m_ee = 1'b0; m_ep = 1'b0;

    // constrained random programs and reads
    for (int it = 0; it < 24; it++) begin
      int idx, ri;
      logic [15:0] dv;
      idx = int'($urandom_range(8, NW - 1));
      dv  = 16'($urandom);
      prog(idx, dv);
      rd_chk(0, exp_stat(1'b1), "R8 random status");
      wr(0, 16'h0050); m_ep = 1'b0;
      ri = int'($urandom_range(0, NW - 1));
      arr_chk(ri, "R5 random array compare");
      arr_chk(idx, "R5 random programmed word");
    end

    // R7 erase all unlocked
    prog(2, 16'hBEEF); prog(25, 16'hCAFE);
    wr(0, 16'h00A7); wr(0, 16'h00D0);
    for (int i = 0; i < NW; i++)
      if (!mlock[i / WPB] && (i / WPB) != PROT) model[i] = 16'hFFFF;
    wait_ready(n);
    arr_chk(2, "R7 protected block kept");
    arr_chk(25, "R7 unlocked block erased");
    arr_chk(17, "R7 locked block kept");
    wr(0, 16'h00A7); wr(0, 16'h0033); m_ee = 1'b1;
    rd_chk(0, exp_stat(1'b1), "R12 abort gives status mode");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule